// File: doc/BRIEF.md
# Dual Calendar Alarm Matcher

This block holds two independent alarm settings and compares each one with the running BCD time of a real-time clock. Each setting has seven byte registers: seconds, minutes, hours, date, month, a year byte and day of week. The top bit of each register switches matching for that one field on or off. The year byte is stored and can be read back, but it never takes part in matching.

The clock drives the current time fields and pulses `tick` once per second. On a tick, a setting matches when at least one of its fields is enabled and every enabled field equals the time. A match sets a sticky status flag, which the host can poll. When the interrupt enable for that alarm is set, the match also drives the active-low interrupt line. The interrupt works in one of two modes: a level that holds until the flag is cleared, or a single-cycle pulse.

The host uses a simple register port with a combinational read and a synchronous write. It clears a flag by writing a one to that flag's bit.

Top module: `alarm_pair_match`

## Requirements
- R1: After reset every register reads 0x00, both flags are clear and `irq_n` is high.
- R2: Alarm 0 fields sit at addresses 0x00 to 0x06 and alarm 1 fields at 0x08 to 0x0E, in the order seconds, minutes, hours, date, month, year, day of week. These registers read back what was written. Addresses 0x07 and 0x0F read 0x00, and writes to them have no effect.
- R3: Bit 7 of each alarm field register enables matching on that field, and bits 6:0 hold the BCD compare value. A field whose bit 7 is 0 does not take part, and the year register never takes part.
- R4: An alarm whose six matchable enable bits are all 0 never sets its flag.
- R5: Matching happens only in a cycle with `tick` high. The flag is visible from the next cycle on, and it sets once for each matching tick.
- R6: The status register at 0x3F holds the alarm 1 flag in bit 6 and the alarm 0 flag in bit 5. Writing a 1 to a flag bit clears that flag, and writing a 0 leaves it unchanged. When a match and a clear land in the same cycle, the flag stays set.
- R7: The control register at 0x11 holds the alarm 1 interrupt enable in bit 6 and the alarm 0 interrupt enable in bit 5. An enable bit gates only `irq_n`. The flag sets whether or not the enable is on.
- R8: With control bit 7 at 0 (level mode), `irq_n` is low for as long as any flag is set together with its enable.
- R9: With control bit 7 at 1 (pulse mode), each triggering tick with the enable on drives `irq_n` low for exactly the following cycle. The flag stays set after the pulse ends.
- R10: The day-of-week field compares only its low three bits against the 3-bit weekday input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per time update |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current date, BCD |
| now_month | input | 5 | Current month, BCD |
| now_dow | input | 3 | Current day of week, 0 to 6 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench sets a flag while the alarm's interrupt enable is off. A design that tied the flag to the mask would leave the status bit clear. It writes a clear and raises a match in the same cycle. A design where the clear wins would lose that event. It runs a tick in which the only differing fields are disabled, and ticks an alarm with no enables at all. These catch designs that ignore the enable bits, or that treat an empty enable set as always matching. It also holds a matching time without a tick, which exposes any matching that does not wait for the strobe. In pulse mode it checks that `irq_n` returns high after one cycle while the flag stays set.

// File: rtl/alarm_pair_match.sv
module alarm_pair_match #(
  parameter int AW = 6,
  parameter logic [AW-1:0] STAT_ADDR = 6'h3F,
  parameter logic [AW-1:0] CTRL_ADDR = 6'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    now_sec,
  input  logic [6:0]    now_min,
  input  logic [5:0]    now_hour,
  input  logic [5:0]    now_date,
  input  logic [4:0]    now_month,
  input  logic [2:0]    now_dow,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_n
);
  localparam int NSET = 2;
  localparam int NF = 7;
  localparam int YR = 5;

  logic [7:0] alm [NSET][NF];
  logic [2:0] ctl;
  logic [1:0] flg;
  logic       pulse_q;
  logic [6:0] tv [NF];
  logic [1:0] hit, arm;

  assign tv[0] = now_sec;
  assign tv[1] = now_min;
  assign tv[2] = {1'b0, now_hour};
  assign tv[3] = {1'b0, now_date};
  assign tv[4] = {2'b0, now_month};
  assign tv[5] = 7'd0;
  assign tv[6] = {4'd0, now_dow};

  genvar s, f;
  generate
    for (s = 0; s < NSET; s++) begin : g_set
      logic [NF-1:0] ok, en;
      for (f = 0; f < NF; f++) begin : g_fld
        if (f == YR) begin : g_skip
          assign en[f] = 1'b0;
          assign ok[f] = 1'b1;
        end else if (f == NF-1) begin : g_dow
          assign en[f] = alm[s][f][7];
          assign ok[f] = !en[f] || (alm[s][f][2:0] == tv[f][2:0]);
        end else begin : g_cmp
          assign en[f] = alm[s][f][7];
          assign ok[f] = !en[f] || (alm[s][f][6:0] == tv[f]);
        end
      end
      assign arm[s] = |en;
      assign hit[s] = arm[s] && (&ok);
    end
  endgenerate

  wire a_sel = reg_we && (reg_addr[AW-1:4] == '0) && (reg_addr[2:0] != 3'd7);
  wire s_wr  = reg_we && (reg_addr == STAT_ADDR);
  wire c_wr  = reg_we && (reg_addr == CTRL_ADDR);
  wire [1:0] clr = s_wr ? reg_wdata[6:5] : 2'b00;
  wire [1:0] set = tick ? hit : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSET; i++)
        for (int j = 0; j < NF; j++)
          alm[i][j] <= 8'h00;
    end else if (a_sel) begin
      alm[reg_addr[3]][reg_addr[2:0]] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= 3'b000;
      flg     <= 2'b00;
      pulse_q <= 1'b0;
    end else begin
      if (c_wr) ctl <= reg_wdata[7:5];
      flg     <= (flg & ~clr) | set;
      pulse_q <= ctl[2] && |(set & ctl[1:0]);
    end
  end

  assign irq_n = ctl[2] ? !pulse_q : !(|(flg & ctl[1:0]));

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == STAT_ADDR)
      reg_rdata = {1'b0, flg, 5'b0};
    else if (reg_addr == CTRL_ADDR)
      reg_rdata = {ctl, 5'b0};
    else if ((reg_addr[AW-1:4] == '0) && (reg_addr[2:0] != 3'd7))
      reg_rdata = alm[reg_addr[3]][reg_addr[2:0]];
  end

  p_flag_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[0]) |-> $past(tick));

  p_empty_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm[1] && !flg[1]) |=> !flg[1]);

  p_flag_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit[0]) |=> flg[0]);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr && reg_wdata[5] && !tick) |=> !flg[0]);

  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[2] && !irq_n && !reg_we) |=> !irq_n);

  p_pulse_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2] && !irq_n && !tick && !reg_we) |=> irq_n);
endmodule

// File: tb/alarm_pair_match_tb.sv
`timescale 1ns/1ps
module alarm_pair_match_tb;
  logic clk = 0, rst_n = 0, tick = 0, reg_we = 0;
  logic [6:0] now_sec = 0, now_min = 0;
  logic [5:0] now_hour = 0, now_date = 0;
  logic [4:0] now_month = 0;
  logic [2:0] now_dow = 0;
  logic [5:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  int        q_kind [$];
  logic [7:0] q_exp [$];
  string     q_tag [$];

  always #4 clk = ~clk;

  alarm_pair_match u_dut (.clk, .rst_n, .tick, .now_sec, .now_min, .now_hour,
    .now_date, .now_month, .now_dow, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .irq_n);

  always @(negedge clk) begin
    #2;
    while (q_kind.size() > 0) begin
      int k; logic [7:0] e, a; string t;
      k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      a = (k == 0) ? reg_rdata : {7'd0, irq_n};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic chk_rd(input logic [5:0] a, input logic [7:0] e, input string t);
    reg_addr = a; q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
  endtask
  task automatic chk_irq(input logic e, input string t);
    q_kind.push_back(1); q_exp.push_back({7'd0, e}); q_tag.push_back(t);
  endtask
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; step(); reg_we = 0;
  endtask
  task automatic do_tick(); tick = 1; step(); tick = 0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    chk_rd(6'h3F, 8'h00, "R1 status"); chk_irq(1, "R1 irq"); step();
    chk_rd(6'h11, 8'h00, "R1 ctrl"); step();
    chk_rd(6'h03, 8'h00, "R1 alarm reg"); step();
    // R2 map
    wr(6'h07, 8'hFF); chk_rd(6'h07, 8'h00, "R2 hole 0x07"); step();
    wr(6'h0F, 8'hFF); chk_rd(6'h0F, 8'h00, "R2 hole 0x0F"); step();
    wr(6'h0E, 8'h85); chk_rd(6'h0E, 8'h85, "R2 a1 dow"); step();
    wr(6'h05, 8'h99); chk_rd(6'h05, 8'h99, "R2 a0 year"); step();
    // alarm0: sec 15, min 30 enabled, year ignored
    wr(6'h00, 8'h95); wr(6'h01, 8'hB0); wr(6'h0E, 8'h05); wr(6'h11, 8'h20);
    now_sec = 7'h15; now_min = 7'h30; now_hour = 6'h12; now_dow = 3'd5;
    step(); step();
    chk_rd(6'h3F, 8'h00, "R5 no tick no flag"); chk_irq(1, "R5 irq"); step();
    do_tick();
    chk_rd(6'h3F, 8'h20, "R3 a0 match"); chk_irq(0, "R8 level low"); step();
    step(); chk_irq(0, "R8 level holds"); step();
    wr(6'h3F, 8'h00); chk_rd(6'h3F, 8'h20, "R6 write 0 keeps"); step();
    wr(6'h3F, 8'h20); chk_rd(6'h3F, 8'h00, "R6 write 1 clears"); chk_irq(1, "R8 release"); step();
    now_min = 7'h31; do_tick();
    chk_rd(6'h3F, 8'h00, "R3 mismatch"); step();
    // R4: alarm1 dow=5 stored but not enabled
    chk_rd(6'h3F, 8'h00, "R4 empty alarm1"); step();
    // R10 / R7: alarm1 dow only, ie1 off
    wr(6'h0E, 8'h85); now_dow = 3'd4; do_tick();
    chk_rd(6'h3F, 8'h00, "R10 dow mismatch"); step();
    now_dow = 3'd5; do_tick();
    chk_rd(6'h3F, 8'h40, "R7 flag unmasked"); chk_irq(1, "R7 irq masked"); step();
    wr(6'h3F, 8'h40); chk_rd(6'h3F, 8'h00, "R6 clear a1"); step();
    // R9 pulse mode
    wr(6'h11, 8'hC0); do_tick();
    chk_irq(0, "R9 pulse low"); chk_rd(6'h3F, 8'h40, "R9 flag"); step();
    chk_irq(1, "R9 pulse ends"); chk_rd(6'h3F, 8'h40, "R9 flag stays"); step();
    do_tick(); chk_irq(0, "R9 second pulse"); step();
    // R6 set wins over clear
    reg_we = 1; reg_addr = 6'h3F; reg_wdata = 8'h40; tick = 1; step();
    reg_we = 0; tick = 0;
    chk_rd(6'h3F, 8'h40, "R6 set wins"); step();
    wr(6'h3F, 8'h60); chk_rd(6'h3F, 8'h00, "R6 clear all"); step();
    step(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule